// File: doc/BRIEF.md
# Transceiver TX Reset Sequencer

This block brings up the transmit side of a serial transceiver in a fixed order. After a reset request it holds the transmit PLL in powerdown. It then holds the analog transmit reset and waits until the PLL reports a lock that has stayed steady. Only after that does it release the digital transmit reset and raise a ready flag. All hold times are given in nanoseconds at elaboration, together with the clock period. Each time is rounded up to a whole number of clock cycles.

The lock status passes through a two-stage synchronizer. It then goes through an optional hysteresis filter, so that a short glitch of lock does not count as lock. A recovery mode chooses what happens when lock drops after bring-up. In auto mode the digital reset is asserted again, and the block waits for lock before it releases it. In manual mode the digital reset is left alone so that the system can decide what to do. The mode can be fixed at elaboration or chosen at run time through an input. One instance can run an independent sequencer per channel, or a single sequencer whose outputs are copied to every channel.

Top module: `tx_reset_seq`

## Requirements
- R1: While a reset request is high, the affected lanes show powerdown=1, analog reset=1, digital reset=1 and ready=0. Asserting the request takes effect at once, without waiting for a clock edge.
- R2: Each duration is converted to cycles as ceil(ns / CLK_PERIOD_NS), with a minimum of 1. For example, 95 ns at a 10 ns clock gives 10 cycles, and 45 ns gives 5 cycles.
- R3: Powerdown deasserts on the PDN-th rising edge that the sequencer advances after the internal reset releases.
- R4: Analog reset deasserts exactly ANA cycles after powerdown deasserts. Analog reset is never low while powerdown is high.
- R5: Lock is sampled through a two-flop synchronizer. It counts as valid only after the synchronized lock has been high for HYST consecutive cycles. A pulse shorter than that is rejected. With HYST=0 the synchronized lock is used with no added delay.
- R6: Once analog reset is low and filtered lock is valid, digital reset deasserts DIG cycles after the first edge that sees the lock. Ready rises on the same edge. Digital reset is never low while analog reset is high.
- R7: In auto mode, if filtered lock is lost while waiting, while counting the digital hold, or while ready, then digital reset is asserted and ready drops on the next edge. The sequence then waits for lock again.
- R8: In manual mode, loss of lock changes neither digital reset nor ready.
- R9: With MODE_CFG=2 the manual_sel input chooses the mode (1 = manual, 0 = auto) and may change at run time. MODE_CFG=0 fixes auto mode and MODE_CFG=1 fixes manual mode.
- R10: With PER_CHANNEL=1, each lane's outputs depend only on that lane's reset request and lock. With PER_CHANNEL=0, one sequencer is reset by the OR of all requests, uses the AND of all locks, and drives every lane with the same values.
- R11: A reset request at any point in the sequence returns the affected sequencer to the powerdown state and restarts the full sequence.
- R12: With SYNC_RESET=1, release of the reset request is delayed by two clock edges through a synchronizer that asserts asynchronously. With SYNC_RESET=0 the request acts on the sequencer directly, and the sequencer advances on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_req | input | NUM_CH | Asynchronous reset request per lane, active high |
| pll_locked | input | NUM_CH | PLL lock status per lane, asynchronous |
| manual_sel | input | 1 | Run-time recovery mode when MODE_CFG=2: 1 manual, 0 auto |
| pll_pdn | output | NUM_CH | PLL powerdown, active high |
| tx_areset | output | NUM_CH | TX analog reset, active high |
| tx_dreset | output | NUM_CH | TX digital reset, active high |
| tx_ready | output | NUM_CH | Lane transmit path is out of reset |

## Verification
If the sequencer state or a duration counter went wrong, a reset output would fall early or late. The error shows on the very edge where the timing departs from the expected count, so it is caught in the first cycle it happens. If the lock filter were wrong, a short lock pulse would release the digital reset, or a real loss of lock in auto mode would fail to raise it again. Either case shows within a few cycles of the lock change. If lanes were coupled in per-channel mode, one lane's output would move in the same cycle as the other lane's stimulus.

// File: rtl/tx_reset_seq.sv
module tx_reset_seq #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int PWRDN_NS      = 1000,
  parameter int ANALOG_NS     = 200,
  parameter int DIGITAL_NS    = 20,
  parameter int LOCK_HYST_NS  = 45,
  parameter bit SYNC_RESET    = 1'b1,
  parameter int MODE_CFG      = 2,
  parameter int NUM_CH        = 2,
  parameter bit PER_CHANNEL   = 1'b1
) (
  input  logic              clk,
  input  logic [NUM_CH-1:0] rst_req,
  input  logic [NUM_CH-1:0] pll_locked,
  input  logic              manual_sel,
  output logic [NUM_CH-1:0] pll_pdn,
  output logic [NUM_CH-1:0] tx_areset,
  output logic [NUM_CH-1:0] tx_dreset,
  output logic [NUM_CH-1:0] tx_ready
);

  localparam int PDN_RAW  = (PWRDN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int ANA_RAW  = (ANALOG_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int DIG_RAW  = (DIGITAL_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int PDN_CYC  = (PDN_RAW < 1) ? 1 : PDN_RAW;
  localparam int ANA_CYC  = (ANA_RAW < 1) ? 1 : ANA_RAW;
  localparam int DIG_CYC  = (DIG_RAW < 1) ? 1 : DIG_RAW;
  localparam int HYST_CYC = (LOCK_HYST_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int MAX_AB   = (PDN_CYC > ANA_CYC) ? PDN_CYC : ANA_CYC;
  localparam int MAX_CYC  = (MAX_AB > DIG_CYC) ? MAX_AB : DIG_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);
  localparam int HW       = $clog2(HYST_CYC + 2);
  localparam int NCTL     = PER_CHANNEL ? NUM_CH : 1;

  typedef enum logic [2:0] {S_PDN, S_ANA, S_WLK, S_DIG, S_RDY} seq_t;

  logic man_eff;
  assign man_eff = (MODE_CFG == 2) ? manual_sel : (MODE_CFG == 1);

  logic [NCTL-1:0] pdn_v, ana_v, dig_v, rdy_v;

  for (genvar g = 0; g < NCTL; g++) begin : ctl
    logic req, lk_in, rst_i, lock_ok;
    logic [1:0] lsync;
    seq_t st, nst;
    logic [CW-1:0] cnt, ncnt;
    logic pdn_q, ana_q, dig_q, rdy_q;

    if (PER_CHANNEL) begin : sel_own
      assign req   = rst_req[g];
      assign lk_in = pll_locked[g];
    end else begin : sel_all
      assign req   = |rst_req;
      assign lk_in = &pll_locked;
    end

    if (SYNC_RESET) begin : rsync
      logic [1:0] sr;
      always_ff @(posedge clk or posedge req)
        if (req) sr <= 2'b11;
        else     sr <= {sr[0], 1'b0};
      assign rst_i = sr[1];
    end else begin : rdirect
      assign rst_i = req;
    end

    always_ff @(posedge clk or posedge rst_i)
      if (rst_i) lsync <= '0;
      else       lsync <= {lsync[0], lk_in};

    if (HYST_CYC == 0) begin : hyst_none
      assign lock_ok = lsync[1];
    end else begin : hyst_cnt
      logic [HW-1:0] hc;
      always_ff @(posedge clk or posedge rst_i)
        if (rst_i)                    hc <= '0;
        else if (!lsync[1])           hc <= '0;
        else if (hc != HW'(HYST_CYC)) hc <= hc + HW'(1);
      assign lock_ok = (hc == HW'(HYST_CYC));
    end

    always_comb begin
      nst  = st;
      ncnt = cnt;
      unique case (st)
        S_PDN:
          if (cnt == CW'(PDN_CYC - 1)) begin nst = S_ANA; ncnt = '0; end
          else ncnt = cnt + CW'(1);
        S_ANA:
          if (cnt == CW'(ANA_CYC - 1)) begin nst = S_WLK; ncnt = '0; end
          else ncnt = cnt + CW'(1);
        S_WLK:
          if (lock_ok) begin nst = S_DIG; ncnt = '0; end
        S_DIG:
          if (!man_eff && !lock_ok) begin nst = S_WLK; ncnt = '0; end
          else if (cnt == CW'(DIG_CYC - 1)) begin nst = S_RDY; ncnt = '0; end
          else ncnt = cnt + CW'(1);
        S_RDY:
          if (!man_eff && !lock_ok) nst = S_WLK;
        default: begin nst = S_PDN; ncnt = '0; end
      endcase
    end

    always_ff @(posedge clk or posedge rst_i)
      if (rst_i) begin
        st    <= S_PDN;
        cnt   <= '0;
        pdn_q <= 1'b1;
        ana_q <= 1'b1;
        dig_q <= 1'b1;
        rdy_q <= 1'b0;
      end else begin
        st    <= nst;
        cnt   <= ncnt;
        pdn_q <= (nst == S_PDN);
        ana_q <= (nst == S_PDN) || (nst == S_ANA);
        dig_q <= (nst != S_RDY);
        rdy_q <= (nst == S_RDY);
      end

    assign pdn_v[g] = pdn_q;
    assign ana_v[g] = ana_q;
    assign dig_v[g] = dig_q;
    assign rdy_v[g] = rdy_q;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : lane
    localparam int SRC = PER_CHANNEL ? c : 0;
    assign pll_pdn[c]   = pdn_v[SRC];
    assign tx_areset[c] = ana_v[SRC];
    assign tx_dreset[c] = dig_v[SRC];
    assign tx_ready[c]  = rdy_v[SRC];
  end

endmodule

// File: rtl/tx_reset_seq_chk.sv
module tx_reset_seq_chk #(
  parameter int NUM_CH   = 2,
  parameter int MODE_CFG = 2
) (
  input logic              clk,
  input logic [NUM_CH-1:0] rst_req,
  input logic              manual_sel,
  input logic [NUM_CH-1:0] pll_pdn,
  input logic [NUM_CH-1:0] tx_areset,
  input logic [NUM_CH-1:0] tx_dreset,
  input logic [NUM_CH-1:0] tx_ready
);
  logic man_eff;
  assign man_eff = (MODE_CFG == 2) ? manual_sel : (MODE_CFG == 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : per_lane
    // R4
    pdn_holds_analog_chk: assert property (@(posedge clk) disable iff (|rst_req)
      pll_pdn[c] |-> tx_areset[c]);
    // R6
    analog_holds_digital_chk: assert property (@(posedge clk) disable iff (|rst_req)
      tx_areset[c] |-> tx_dreset[c]);
    // R6
    ready_after_analog_chk: assert property (@(posedge clk) disable iff (|rst_req)
      $rose(tx_ready[c]) |-> !$past(tx_areset[c]));
    // R8
    manual_keeps_ready_chk: assert property (@(posedge clk) disable iff (|rst_req)
      ($past(tx_ready[c]) && man_eff && $past(man_eff)) |-> tx_ready[c]);
  end
endmodule

bind tx_reset_seq tx_reset_seq_chk #(.NUM_CH(NUM_CH), .MODE_CFG(MODE_CFG)) chk_i (
  .clk(clk), .rst_req(rst_req), .manual_sel(manual_sel), .pll_pdn(pll_pdn),
  .tx_areset(tx_areset), .tx_dreset(tx_dreset), .tx_ready(tx_ready));

// File: tb/tx_reset_seq_test.sv
module tx_reset_ref #(
  parameter int P = 1, parameter int A = 1, parameter int D = 1, parameter int H = 0,
  parameter bit SYNC = 1'b1, parameter int MODE = 0
) (
  input  logic clk, input logic req, input logic lk, input logic man,
  output logic e_pdn, output logic e_ana, output logic e_dig, output logic e_rdy
);
  integer rs1 = 1, rs2 = 1, l1 = 0, l2 = 0, hc = 0, st = 0, cnt = 0;
  bit rold, ok, m;
  always @(posedge clk) begin
    if (req) begin rs1 = 1; rs2 = 1; rold = 1; end
    else if (SYNC) begin rold = (rs2 != 0); rs2 = rs1; rs1 = 0; end
    else rold = 0;
    if (rold) begin l1 = 0; l2 = 0; hc = 0; st = 0; cnt = 0; end
    else begin
      ok = (H == 0) ? (l2 != 0) : (hc >= H);
      m  = (MODE == 2) ? man : (MODE == 1);
      hc = (l2 != 0) ? ((hc < H) ? hc + 1 : hc) : 0;
      l2 = l1; l1 = lk;
      case (st)
        0: if (cnt == P - 1) begin st = 1; cnt = 0; end else cnt++;
        1: if (cnt == A - 1) begin st = 2; cnt = 0; end else cnt++;
        2: if (ok) begin st = 3; cnt = 0; end
        3: if (!m && !ok) begin st = 2; cnt = 0; end
           else if (cnt == D - 1) begin st = 4; cnt = 0; end else cnt++;
        default: if (!m && !ok) st = 2;
      endcase
    end
    e_pdn = (st == 0); e_ana = (st <= 1); e_dig = (st != 4); e_rdy = (st == 4);
  end
endmodule

module tx_reset_seq_test;
  localparam int CLK_NS = 10;
  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic [1:0] rq = 2'b00, lk = 2'b00;
  logic man = 1'b0;
  logic [1:0] a_pdn, a_ana, a_dig, a_rdy, s_pdn, s_ana, s_dig, s_rdy;
  logic [1:0] e_pdn, e_ana, e_dig, e_rdy;
  logic es_pdn, es_ana, es_dig, es_rdy;
  int checks = 0, fails = 0;
  bit live = 1'b0;

  tx_reset_seq #(.CLK_PERIOD_NS(CLK_NS), .PWRDN_NS(1000), .ANALOG_NS(200), .DIGITAL_NS(20),
    .LOCK_HYST_NS(45), .SYNC_RESET(1'b1), .MODE_CFG(2), .NUM_CH(2), .PER_CHANNEL(1'b1)) uut (
    .clk(clk), .rst_req(rq), .pll_locked(lk), .manual_sel(man),
    .pll_pdn(a_pdn), .tx_areset(a_ana), .tx_dreset(a_dig), .tx_ready(a_rdy));

  tx_reset_seq #(.CLK_PERIOD_NS(CLK_NS), .PWRDN_NS(95), .ANALOG_NS(55), .DIGITAL_NS(20),
    .LOCK_HYST_NS(0), .SYNC_RESET(1'b0), .MODE_CFG(0), .NUM_CH(2), .PER_CHANNEL(1'b0)) uut_sh (
    .clk(clk), .rst_req(rq), .pll_locked(lk), .manual_sel(man),
    .pll_pdn(s_pdn), .tx_areset(s_ana), .tx_dreset(s_dig), .tx_ready(s_rdy));

  for (genvar c = 0; c < 2; c++) begin : mdl
    tx_reset_ref #(.P(100), .A(20), .D(2), .H(5), .SYNC(1'b1), .MODE(2)) m (
      .clk(clk), .req(rq[c]), .lk(lk[c]), .man(man),
      .e_pdn(e_pdn[c]), .e_ana(e_ana[c]), .e_dig(e_dig[c]), .e_rdy(e_rdy[c]));
  end
  tx_reset_ref #(.P(10), .A(6), .D(2), .H(0), .SYNC(1'b0), .MODE(0)) msh (
    .clk(clk), .req(|rq), .lk(&lk), .man(man),
    .e_pdn(es_pdn), .e_ana(es_ana), .e_dig(es_dig), .e_rdy(es_rdy));

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    for (int c = 0; c < 2; c++) begin
      chk(a_pdn[c], e_pdn[c], "R3 per-lane powerdown");
      chk(a_ana[c], e_ana[c], "R4 per-lane analog reset");
      chk(a_dig[c], e_dig[c], "R7 per-lane digital reset");
      chk(a_rdy[c], e_rdy[c], "R6 per-lane ready");
      chk(s_pdn[c], es_pdn, "R10 shared powerdown");
      chk(s_ana[c], es_ana, "R10 shared analog reset");
      chk(s_dig[c], es_dig, "R10 shared digital reset");
      chk(s_rdy[c], es_rdy, "R10 shared ready");
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (live) cmp_all();
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 20000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1 rq = 2'b11; lk = 2'b00;
    #1;
    chk(a_pdn[0], 1'b1, "R1 async powerdown on request");
    chk(s_pdn[0], 1'b1, "R12 direct reset acts at once");
    @(posedge clk); live = 1'b1;
    step(5);
    chk(a_pdn[0], 1'b1, "R1 pdn in reset");
    chk(a_ana[1], 1'b1, "R1 analog in reset");
    chk(a_dig[0], 1'b1, "R1 digital in reset");
    chk(a_rdy[1], 1'b0, "R1 ready in reset");

    rq = 2'b00; lk = 2'b11;
    step(9);  chk(s_pdn[0], 1'b1, "R2 95ns rounds to 10 cycles (held)");
    step(1);  chk(s_pdn[0], 1'b0, "R2 R12 shared pdn released at edge 10");
    step(91); chk(a_pdn[0], 1'b1, "R3 pdn held before edge 102");
    step(1);  chk(a_pdn[0], 1'b0, "R3 pdn released at edge 102");
    step(19); chk(a_ana[0], 1'b1, "R4 analog held 19 cycles");
    step(1);  chk(a_ana[0], 1'b0, "R4 analog released after 20");
    step(2);  chk(a_dig[0], 1'b1, "R6 digital still held");
    step(1);  chk(a_dig[0], 1'b0, "R6 digital released");
              chk(a_rdy[0], 1'b1, "R6 ready raised");

    lk = 2'b10;
    step(3);  chk(a_dig[0], 1'b0, "R7 digital low before filtered loss");
    step(1);  chk(a_dig[0], 1'b1, "R7 auto loss reasserts digital");
              chk(a_rdy[0], 1'b0, "R7 ready dropped");
              chk(a_dig[1], 1'b0, "R10 other lane untouched");
    lk = 2'b11;
    step(3);
    lk = 2'b10;
    step(8);  chk(a_dig[0], 1'b1, "R5 short lock pulse rejected");
    lk = 2'b11;
    step(20); chk(a_rdy[0], 1'b1, "R5 steady lock accepted");

    man = 1'b1; lk = 2'b01;
    step(10); chk(a_rdy[1], 1'b1, "R8 manual keeps ready");
              chk(a_dig[1], 1'b0, "R8 manual keeps digital low");
    man = 1'b0;
    step(2);  chk(a_dig[1], 1'b1, "R9 switch to auto reasserts digital");
    lk = 2'b11;
    step(20);

    rq = 2'b01;
    #1;
    chk(a_pdn[0], 1'b1, "R11 request forces powerdown");
    chk(a_pdn[1], 1'b0, "R10 lane 1 not reset");
    chk(s_pdn[1], 1'b1, "R12 shared reset immediate");
    step(2);
    rq = 2'b00;
    step(110);
    chk(a_pdn[0], 1'b0, "R11 pdn released in restart");
    chk(a_ana[0], 1'b1, "R11 analog phase in restart");
    rq = 2'b01;
    step(1);
    rq = 2'b00;
    step(5);  chk(a_pdn[0], 1'b1, "R11 mid-analog request restarts powerdown");
    step(140); chk(a_rdy[0], 1'b1, "R11 ready after full restart");
    finish_run();
  end
endmodule